// File: doc/BRIEF.md
# Byte-Bus Burst SRAM Address Sequencer

This block lets a microcontroller with only an 8-bit data path and one strobe line reach a large external static RAM. The host never drives address pins. It first sends a header over the shared byte bus, one byte per strobe. The header holds a start address and a transfer length. After that, every further strobe moves the memory pointer on by one location. The sequencer drives the SRAM address lines, the chip, output and write enables, and a flag that tells the board which side owns the data bus.

A header opens with a byte whose top bit is set. The bit below the top bit selects write mode, and the lowest bits give the upper part of the address. Two address bytes follow, middle byte then low byte. Then come two length bytes, high byte first. In the burst phase each strobe completes one memory access, advances the address and lowers the remaining length. The block goes back to waiting for a header by itself when the length runs out. The strobe is asynchronous to the block clock. It is synchronised inside the block, and only its rising edge is used.

Top module: `burst_seq`

## Requirements
- R1: A synchronous active-high reset puts the block in the waiting state. It drives sram_ce_n, sram_oe_n and sram_we_n high, sets bus_dir to 0 and clears the address to zero.
- R2: While waiting, a strobed byte with bit 7 equal to 0 is ignored. The outputs do not change, and the next header byte is still taken as the first byte of a header.
- R3: A strobed byte with bit 7 equal to 1, received while waiting, starts a header. Bit 6 selects the mode (1 = write, 0 = read), and bits 5:0 become address bits 21:16.
- R4: The next four strobes load, in order, address bits 15:8, address bits 7:0, length bits 15:8 and length bits 7:0.
- R5: In the burst phase each strobe raises sram_addr by one, wrapping from 0x3FFFFF to 0, and lowers the remaining length by one.
- R6: When the strobe that brings the remaining length to zero is taken, the block returns to the waiting state and raises sram_ce_n.
- R7: A loaded length of zero returns the block to waiting at once. No enable is asserted.
- R8: In a read burst, sram_ce_n and sram_oe_n stay low and bus_dir is 1 for the whole burst, while sram_we_n stays high.
- R9: In a write burst, sram_oe_n stays high and bus_dir is 0. sram_we_n goes low for exactly one clock per strobe, at the address in force before that strobe's increment.
- R10: Each rising edge of strobe advances the sequence exactly once, however long strobe is held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Host strobe, asynchronous |
| bus_in | input | 8 | Byte currently on the shared bus |
| sram_addr | output | 22 | SRAM address |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| bus_dir | output | 1 | 1 = SRAM drives the bus (read), 0 = host drives it |

## Verification
The hardest conditions to reach from the ports are the two ends of a burst: the final strobe that empties the length counter, and a header whose length is zero. Both only appear after a full five-byte header has been sent. The stimulus table therefore steps through complete headers with lengths of 0, 1 and several strobes. One header starts just below the top of the address space, so that the address wrap falls inside the burst. Write-enable pulses are counted at the pins and compared with the length. A strobe held high for many clocks, a byte without the start flag, and a reset in the middle of a burst are added as directed cases.

// File: rtl/burst_pkg.sv
package burst_pkg;
   typedef enum logic [2:0] {
      ST_WAIT  = 3'd0,
      ST_AMID  = 3'd1,
      ST_ALO   = 3'd2,
      ST_LHI   = 3'd3,
      ST_LLO   = 3'd4,
      ST_BURST = 3'd5
   } seq_state_t;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic strobe,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= strobe;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], strobe};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) last <= 1'b0;
      else     last <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last;

   initial assert (STAGES >= 1) else $error("STAGES must be at least 1");

   p_single_rise_r10: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);
endmodule

// File: rtl/ptr_regs.sv
module ptr_regs #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 22
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              ld_hi,
   input  logic              ld_mid,
   input  logic              ld_lo,
   input  logic              ld_len_hi,
   input  logic              ld_len_lo,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic              len_hi_zero,
   output logic              len_is_one
);
   localparam int HI_W  = ADDR_W - 2*DATA_W;
   localparam int LEN_W = 2*DATA_W;

   logic [LEN_W-1:0] len;

   always_ff @(posedge clk) begin
      if (rst) begin
         addr <= '0;
      end else if (ld_hi) begin
         addr[ADDR_W-1 -: HI_W] <= byte_in[HI_W-1:0];
      end else if (ld_mid) begin
         addr[2*DATA_W-1 -: DATA_W] <= byte_in;
      end else if (ld_lo) begin
         addr[DATA_W-1:0] <= byte_in;
      end else if (step) begin
         addr <= addr + {{(ADDR_W-1){1'b0}}, 1'b1};
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         len <= '0;
      end else if (ld_len_hi) begin
         len[LEN_W-1 -: DATA_W] <= byte_in;
      end else if (ld_len_lo) begin
         len[DATA_W-1:0] <= byte_in;
      end else if (step) begin
         len <= len - {{(LEN_W-1){1'b0}}, 1'b1};
      end
   end

   assign len_hi_zero = (len[LEN_W-1 -: DATA_W] == '0);
   assign len_is_one  = (len == {{(LEN_W-1){1'b0}}, 1'b1});

   p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
      (step && !ld_hi && !ld_mid && !ld_lo) |=>
         addr == $past(addr) + {{(ADDR_W-1){1'b0}}, 1'b1});
   p_len_step_r5: assert property (@(posedge clk) disable iff (rst)
      (step && !ld_len_hi && !ld_len_lo) |=>
         len == $past(len) - {{(LEN_W-1){1'b0}}, 1'b1});
   p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
      !(step || ld_hi || ld_mid || ld_lo || ld_len_hi || ld_len_lo) |=>
         $stable(addr) && $stable(len));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
   import burst_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rise,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              len_hi_zero,
   input  logic              len_is_one,
   output seq_state_t        state,
   output logic              wr_mode,
   output logic              ld_hi,
   output logic              ld_mid,
   output logic              ld_lo,
   output logic              ld_len_hi,
   output logic              ld_len_lo,
   output logic              step
);
   localparam int FLAG_BIT = DATA_W - 1;
   localparam int MODE_BIT = DATA_W - 2;

   seq_state_t nxt;
   logic       start;
   logic       zero_len;

   assign start     = rise && (state == ST_WAIT) && byte_in[FLAG_BIT];
   assign ld_hi     = start;
   assign ld_mid    = rise && (state == ST_AMID);
   assign ld_lo     = rise && (state == ST_ALO);
   assign ld_len_hi = rise && (state == ST_LHI);
   assign ld_len_lo = rise && (state == ST_LLO);
   assign step      = rise && (state == ST_BURST);
   assign zero_len  = len_hi_zero && (byte_in == '0);

   always_comb begin
      nxt = state;
      unique case (state)
         ST_WAIT:  if (start)     nxt = ST_AMID;
         ST_AMID:  if (rise)      nxt = ST_ALO;
         ST_ALO:   if (rise)      nxt = ST_LHI;
         ST_LHI:   if (rise)      nxt = ST_LLO;
         ST_LLO:   if (rise)      nxt = zero_len ? ST_WAIT : ST_BURST;
         ST_BURST: if (rise && len_is_one) nxt = ST_WAIT;
         default:                 nxt = ST_WAIT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_WAIT;
         wr_mode <= 1'b0;
      end else begin
         state <= nxt;
         if (start) wr_mode <= byte_in[MODE_BIT];
      end
   end

   p_zero_len_exit_r7: assert property (@(posedge clk) disable iff (rst)
      (ld_len_lo && len_hi_zero && byte_in == '0) |=> state == ST_WAIT);
   p_last_exit_r6: assert property (@(posedge clk) disable iff (rst)
      (step && len_is_one) |=> state == ST_WAIT);
   p_no_flag_ignored_r2: assert property (@(posedge clk) disable iff (rst)
      (state == ST_WAIT && !byte_in[FLAG_BIT]) |=> state == ST_WAIT);
endmodule

// File: rtl/burst_seq.sv
module burst_seq
   import burst_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 22,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              strobe,
   input  logic [DATA_W-1:0] bus_in,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_ce_n,
   output logic              sram_oe_n,
   output logic              sram_we_n,
   output logic              bus_dir
);
   localparam int HI_W = ADDR_W - 2*DATA_W;

   initial assert (HI_W >= 1 && HI_W <= DATA_W - 2)
      else $error("ADDR_W leaves no room for flag and mode bits");

   logic       rise, wr_mode, step;
   logic       ld_hi, ld_mid, ld_lo, ld_len_hi, ld_len_lo;
   logic       len_hi_zero, len_is_one;
   seq_state_t state;
   logic       in_burst;

   strobe_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst(rst), .strobe(strobe), .rise(rise)
   );

   seq_fsm #(.DATA_W(DATA_W)) u_fsm (
      .clk(clk), .rst(rst), .rise(rise), .byte_in(bus_in),
      .len_hi_zero(len_hi_zero), .len_is_one(len_is_one),
      .state(state), .wr_mode(wr_mode),
      .ld_hi(ld_hi), .ld_mid(ld_mid), .ld_lo(ld_lo),
      .ld_len_hi(ld_len_hi), .ld_len_lo(ld_len_lo), .step(step)
   );

   ptr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst(rst), .byte_in(bus_in),
      .ld_hi(ld_hi), .ld_mid(ld_mid), .ld_lo(ld_lo),
      .ld_len_hi(ld_len_hi), .ld_len_lo(ld_len_lo), .step(step),
      .addr(sram_addr), .len_hi_zero(len_hi_zero), .len_is_one(len_is_one)
   );

   assign in_burst  = (state == ST_BURST);
   assign sram_ce_n = ~in_burst;
   assign sram_oe_n = ~(in_burst & ~wr_mode);
   assign sram_we_n = ~(step & wr_mode);
   assign bus_dir   = in_burst & ~wr_mode;

   p_enables_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
      !(!sram_oe_n && !sram_we_n));
   p_oe_needs_ce_r8: assert property (@(posedge clk) disable iff (rst)
      !sram_oe_n |-> !sram_ce_n);
   p_we_single_r9: assert property (@(posedge clk) disable iff (rst)
      !sram_we_n |=> sram_we_n);
   p_dir_write_r9: assert property (@(posedge clk) disable iff (rst)
      !sram_we_n |-> !bus_dir);
endmodule

// File: tb/tb_burst_seq.sv
module tb_burst_seq;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        strobe = 1'b0;
   logic [7:0]  bus_in = 8'h00;
   logic [21:0] sram_addr;
   logic        sram_ce_n, sram_oe_n, sram_we_n, bus_dir;

   int checks = 0;
   int fails  = 0;
   int we_pulses = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   burst_seq dut (
      .clk(clk), .rst(rst), .strobe(strobe), .bus_in(bus_in),
      .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
      .sram_we_n(sram_we_n), .bus_dir(bus_dir)
   );

   always @(negedge clk) if (!sram_we_n) we_pulses++;

   // {write, start address, length}
   localparam logic [38:0] VECS [4] = '{
      {1'b0, 22'h012345, 16'd3},
      {1'b1, 22'h3FFFFE, 16'd4},
      {1'b0, 22'h2A0F0F, 16'd1},
      {1'b1, 22'h000100, 16'd0}
   };

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b, input int hold);
      @(negedge clk);
      bus_in = b;
      strobe = 1'b1;
      repeat (hold) @(negedge clk);
      strobe = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic header(input logic wr, input logic [21:0] a, input logic [15:0] n);
      send({1'b1, wr, a[21:16]}, 4);
      send(a[15:8], 4);
      send(a[7:0], 4);
      send(n[15:8], 4);
      send(n[7:0], 4);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      check(sram_ce_n && sram_oe_n && sram_we_n && !bus_dir, "R1 enables",
            {sram_ce_n, sram_oe_n, sram_we_n, bus_dir}, 4'b1110);
      check(sram_addr == 22'h0, "R1 address", sram_addr, 0);

      for (int v = 0; v < 4; v++) begin
         logic        wr;
         logic [21:0] a;
         logic [15:0] n;
         {wr, a, n} = VECS[v];
         we_pulses = 0;
         header(wr, a, n);
         // R3 R4 address assembled from header bytes
         check(sram_addr == a, "R4 loaded address", sram_addr, a);
         if (n == 16'd0) begin
            check(sram_ce_n && sram_oe_n, "R7 zero length stays idle",
                  {sram_ce_n, sram_oe_n}, 2'b11);
         end else begin
            check(!sram_ce_n, "R3 burst entered", sram_ce_n, 0);
            check(sram_oe_n == wr && bus_dir == !wr, "R8 R9 direction/oe by mode",
                  {sram_oe_n, bus_dir}, {wr, !wr});
         end
         for (int k = 0; k < int'(n); k++) begin
            check(sram_addr == a + 22'(k), "R5 address step", sram_addr, a + 22'(k));
            check(!sram_ce_n && (wr || (!sram_oe_n && bus_dir)), "R8 enables held",
                  {sram_ce_n, sram_oe_n, bus_dir}, {1'b0, wr, !wr});
            send(8'h00, 4);
         end
         check(sram_ce_n, "R6 exit after length", sram_ce_n, 1);
         check(sram_addr == a + 22'(n), "R5 final address", sram_addr, a + 22'(n));
         check(we_pulses == (wr ? int'(n) : 0), "R9 write pulses", we_pulses,
               wr ? int'(n) : 0);
      end

      // R2 byte without flag ignored, next header still starts
      send(8'h7F, 4);
      check(sram_ce_n && sram_addr == 22'h000100, "R2 ignored byte",
            sram_addr, 22'h000100);
      send(8'h40, 4);
      header(1'b0, 22'h000010, 16'd3);
      check(!sram_ce_n && sram_addr == 22'h000010, "R2 header after ignored bytes",
            sram_addr, 22'h000010);

      // R10 long strobe counts once
      send(8'h00, 20);
      check(sram_addr == 22'h000011, "R10 long strobe single step", sram_addr, 22'h000011);

      // R1 reset mid-burst
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      @(negedge clk);
      check(sram_ce_n && sram_oe_n && !bus_dir && sram_addr == 22'h0,
            "R1 reset mid-burst", {sram_ce_n, sram_oe_n, bus_dir}, 3'b110);

      finish_run();
   end
endmodule